// File: doc/BRIEF.md
# Fabric Swap-In Manager

This block is the fallback network endpoint for method-call packets whose target functional unit is not currently loaded into reconfigurable fabric. It keeps a small table of resident unit addresses and answers for every address that is not in that table. When such a packet arrives, the manager holds it, works out which unit it targets, and picks a free fabric slot. It then asks an external loader to bring that unit in, and delivers the held packet to the unit once the loader acknowledges. From then on it stops answering for that address.

When a loaded unit signals that it has finished, the manager marks its slot empty. That address falls back into the set the manager answers for, and the slot becomes free for the next load. Only one load is in flight at a time. Any packet offered during that time is held off. When every slot is occupied, a new miss waits until a unit finishes.

Top module: `fu_swap_manager`

## Requirements
- R1: After reset every slot is empty, `claim` is high for any address, and `load_req` and `fwd_valid` are low.
- R2: While idle, a packet whose `in_addr` is not resident is accepted (`in_ready` high, `claim` high) on the rising edge where `in_valid` is high.
- R3: An accepted packet produces exactly one single-cycle `load_req` pulse, with `load_addr` equal to the packet address and `load_slot` naming the chosen slot.
- R4: `fwd_valid` rises only in the cycle after `load_ack` was high, and `fwd_addr`, `fwd_data` and `fwd_slot` carry the held packet unchanged until `fwd_ready` is seen.
- R5: Once the forward handshake completes, the address is resident: `claim` and `in_ready` stay low for it, and no further load is issued for it.
- R6: A `done_valid` pulse naming an occupied slot empties that slot, and its address is claimed again from the next cycle.
- R7: From acceptance until the slot is installed, `in_ready` is low for every address, including the one being loaded.
- R8: With all slots occupied, an accepted miss issues no `load_req` until a completion frees a slot, and then loads into the freed slot.
- R9: The slot chosen for a load is the lowest-numbered slot that is neither occupied nor being loaded.
- R10: A `done_valid` pulse naming an empty slot changes no other slot, so every other resident address stays unclaimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming packet present |
| in_addr | input | 12 | Destination unit address of the incoming packet |
| in_data | input | 32 | Packet payload |
| in_ready | output | 1 | Manager takes the packet at this edge |
| claim | output | 1 | `in_addr` is not resident, so the manager answers for it |
| load_req | output | 1 | One-cycle request to load a unit |
| load_addr | output | 12 | Unit to load |
| load_slot | output | 2 | Fabric slot to load into |
| load_ack | input | 1 | Loader finished the requested load |
| fwd_valid | output | 1 | Held packet offered to the loaded unit |
| fwd_ready | input | 1 | Loaded unit takes the packet |
| fwd_addr | output | 12 | Address of the forwarded packet |
| fwd_data | output | 32 | Payload of the forwarded packet |
| fwd_slot | output | 2 | Slot holding the target unit |
| done_valid | input | 1 | A loaded unit has finished |
| done_slot | input | 2 | Slot of the finishing unit |

## Verification
The assertions take for granted that `load_ack` arrives only while a load request is outstanding and that a completion pulse names a slot rather than an address. They also assume a loaded unit does not signal completion before its packet has been forwarded. The stimulus keeps to this. A responder raises `load_ack` for one cycle two cycles after each `load_req`. Completion pulses are issued only once the forward handshake is over, and one deliberate pulse names an empty slot to exercise the ignore rule.

// File: rtl/swap_pkg.sv
package swap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_DECODE   = 3'd1,
        ST_LOAD_REQ = 3'd2,
        ST_WAIT_ACK = 3'd3,
        ST_FORWARD  = 3'd4,
        ST_RELEASE  = 3'd5
    } swap_state_e;

endpackage

// File: rtl/swap_free_pick.sv
module swap_free_pick #(
    parameter int N_SLOTS = 4,
    localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic [N_SLOTS-1:0] busy,
    output logic               found,
    output logic [SLOT_W-1:0]  idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = SLOT_W'(i);
            end
        end
    end

endmodule

// File: rtl/swap_slot_table.sv
module swap_slot_table #(
    parameter int N_SLOTS = 4,
    parameter int ADDR_W  = 12,
    localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  look_addr,
    output logic               hit,
    input  logic               install_en,
    input  logic [SLOT_W-1:0]  install_slot,
    input  logic [ADDR_W-1:0]  install_addr,
    input  logic               clear_en,
    input  logic [SLOT_W-1:0]  clear_slot,
    output logic [N_SLOTS-1:0] valid_vec
);

    typedef struct packed {
        logic [N_SLOTS-1:0]             valid;
        logic [N_SLOTS-1:0][ADDR_W-1:0] addr;
    } table_t;

    table_t tbl_q, tbl_d;
    logic [N_SLOTS-1:0] match;

    generate
        for (genvar s = 0; s < N_SLOTS; s++) begin : g_match
            assign match[s] = tbl_q.valid[s] && (tbl_q.addr[s] == look_addr);
        end
    endgenerate

    assign hit       = |match;
    assign valid_vec = tbl_q.valid;

    always_comb begin
        tbl_d = tbl_q;
        if (clear_en && tbl_q.valid[clear_slot]) begin
            tbl_d.valid[clear_slot] = 1'b0;
        end
        if (install_en) begin
            tbl_d.valid[install_slot] = 1'b1;
            tbl_d.addr[install_slot]  = install_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // R5
    generate
        for (genvar i = 0; i < N_SLOTS; i++) begin : g_uniq_i
            for (genvar j = i + 1; j < N_SLOTS; j++) begin : g_uniq_j
                unique_resident_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    !(tbl_q.valid[i] && tbl_q.valid[j] && (tbl_q.addr[i] == tbl_q.addr[j])));
            end
        end
    endgenerate

    // R6
    done_empties_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_en && tbl_q.valid[clear_slot] && !(install_en && install_slot == clear_slot))
        |=> !tbl_q.valid[$past(clear_slot)]);

endmodule

// File: rtl/swap_ctrl.sv
module swap_ctrl
    import swap_pkg::*;
#(
    parameter int N_SLOTS = 4,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              hit,
    output logic              in_ready,
    input  logic              free_found,
    input  logic [SLOT_W-1:0] free_idx,
    output logic              load_req,
    output logic [ADDR_W-1:0] load_addr,
    output logic [SLOT_W-1:0] load_slot,
    input  logic              load_ack,
    output logic              fwd_valid,
    input  logic              fwd_ready,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [DATA_W-1:0] fwd_data,
    output logic [SLOT_W-1:0] fwd_slot,
    output logic              install_en,
    output logic [SLOT_W-1:0] install_slot,
    output logic [ADDR_W-1:0] install_addr,
    output logic              pend_valid,
    output logic [SLOT_W-1:0] pend_slot
);

    typedef struct packed {
        swap_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [SLOT_W-1:0] slot;
    } ctrl_t;

    ctrl_t c_q, c_d;

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            ST_IDLE: begin
                if (in_valid && !hit) begin
                    c_d.addr = in_addr;
                    c_d.data = in_data;
                    c_d.st   = ST_DECODE;
                end
            end
            ST_DECODE: begin
                if (free_found) begin
                    c_d.slot = free_idx;
                    c_d.st   = ST_LOAD_REQ;
                end
            end
            ST_LOAD_REQ: c_d.st = ST_WAIT_ACK;
            ST_WAIT_ACK: begin
                if (load_ack) c_d.st = ST_FORWARD;
            end
            ST_FORWARD: begin
                if (fwd_ready) c_d.st = ST_RELEASE;
            end
            ST_RELEASE: c_d.st = ST_IDLE;
            default:    c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, addr: '0, data: '0, slot: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign in_ready     = (c_q.st == ST_IDLE) && !hit;
    assign load_req     = (c_q.st == ST_LOAD_REQ);
    assign load_addr    = c_q.addr;
    assign load_slot    = c_q.slot;
    assign fwd_valid    = (c_q.st == ST_FORWARD);
    assign fwd_addr     = c_q.addr;
    assign fwd_data     = c_q.data;
    assign fwd_slot     = c_q.slot;
    assign install_en   = (c_q.st == ST_RELEASE);
    assign install_slot = c_q.slot;
    assign install_addr = c_q.addr;
    assign pend_valid   = (c_q.st == ST_LOAD_REQ) || (c_q.st == ST_WAIT_ACK) ||
                          (c_q.st == ST_FORWARD)  || (c_q.st == ST_RELEASE);
    assign pend_slot    = c_q.slot;

    // R3
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> !load_req);

    // R4
    fwd_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fwd_valid) |-> $past(load_ack));

    // R4
    fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_addr) &&
                                       $stable(fwd_data) && $stable(fwd_slot)));

    // R7
    busy_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

endmodule

// File: rtl/fu_swap_manager.sv
module fu_swap_manager #(
    parameter int N_SLOTS = 4,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              claim,
    output logic              load_req,
    output logic [ADDR_W-1:0] load_addr,
    output logic [SLOT_W-1:0] load_slot,
    input  logic              load_ack,
    output logic              fwd_valid,
    input  logic              fwd_ready,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [DATA_W-1:0] fwd_data,
    output logic [SLOT_W-1:0] fwd_slot,
    input  logic              done_valid,
    input  logic [SLOT_W-1:0] done_slot
);

    logic               hit;
    logic [N_SLOTS-1:0] valid_vec;
    logic [N_SLOTS-1:0] busy_vec;
    logic               free_found;
    logic [SLOT_W-1:0]  free_idx;
    logic               install_en;
    logic [SLOT_W-1:0]  install_slot;
    logic [ADDR_W-1:0]  install_addr;
    logic               pend_valid;
    logic [SLOT_W-1:0]  pend_slot;

    always_comb begin
        busy_vec = valid_vec;
        if (pend_valid) busy_vec[pend_slot] = 1'b1;
    end

    assign claim = !hit;

    swap_slot_table #(.N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W)) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .look_addr   (in_addr),
        .hit         (hit),
        .install_en  (install_en),
        .install_slot(install_slot),
        .install_addr(install_addr),
        .clear_en    (done_valid),
        .clear_slot  (done_slot),
        .valid_vec   (valid_vec)
    );

    swap_free_pick #(.N_SLOTS(N_SLOTS)) u_pick (
        .busy (busy_vec),
        .found(free_found),
        .idx  (free_idx)
    );

    swap_ctrl #(.N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_addr     (in_addr),
        .in_data     (in_data),
        .hit         (hit),
        .in_ready    (in_ready),
        .free_found  (free_found),
        .free_idx    (free_idx),
        .load_req    (load_req),
        .load_addr   (load_addr),
        .load_slot   (load_slot),
        .load_ack    (load_ack),
        .fwd_valid   (fwd_valid),
        .fwd_ready   (fwd_ready),
        .fwd_addr    (fwd_addr),
        .fwd_data    (fwd_data),
        .fwd_slot    (fwd_slot),
        .install_en  (install_en),
        .install_slot(install_slot),
        .install_addr(install_addr),
        .pend_valid  (pend_valid),
        .pend_slot   (pend_slot)
    );

    // R9
    load_slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |-> !valid_vec[load_slot]);

    // R8
    full_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&valid_vec) |=> !load_req);

endmodule

// File: tb/sim_fu_swap_manager.sv
module sim_fu_swap_manager;

    localparam int AW = 12;
    localparam int DW = 32;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [AW-1:0] in_addr = '0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready, claim, load_req, fwd_valid;
    logic [AW-1:0] load_addr, fwd_addr;
    logic [SW-1:0] load_slot, fwd_slot;
    logic [DW-1:0] fwd_data;
    logic          load_ack = 1'b0;
    logic          fwd_ready = 1'b1;
    logic          done_valid = 1'b0;
    logic [SW-1:0] done_slot = '0;

    int checks = 0;
    int fails  = 0;
    int loads_seen = 0;
    int fwds_seen  = 0;

    logic [AW+SW-1:0]    load_q[$];
    logic [AW+DW+SW-1:0] fwd_q[$];

    always #10 clk = ~clk;

    fu_swap_manager u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_data(in_data), .in_ready(in_ready), .claim(claim),
        .load_req(load_req), .load_addr(load_addr), .load_slot(load_slot),
        .load_ack(load_ack), .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
        .fwd_addr(fwd_addr), .fwd_data(fwd_data), .fwd_slot(fwd_slot),
        .done_valid(done_valid), .done_slot(done_slot)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected load requests and forwards
    always @(negedge clk) begin
        if (rst_n) begin
            if (load_req) begin
                loads_seen++;
                if (load_q.size() == 0) begin
                    check(1'b0, "R3/R5 unexpected load", {load_addr, load_slot}, 0);
                end else begin
                    logic [AW+SW-1:0] e;
                    e = load_q.pop_front();
                    check({load_addr, load_slot} == e, "R3/R9 load addr,slot", {load_addr, load_slot}, e);
                end
            end
            if (fwd_valid && fwd_ready) begin
                fwds_seen++;
                if (fwd_q.size() == 0) begin
                    check(1'b0, "R4 unexpected forward", fwd_addr, 0);
                end else begin
                    logic [AW+DW+SW-1:0] f;
                    f = fwd_q.pop_front();
                    check({fwd_addr, fwd_data, fwd_slot} == f, "R4 forward addr,data,slot",
                          {fwd_addr, fwd_data, fwd_slot}, f);
                end
            end
        end
    end

    // Loader model: acknowledge two cycles after each request
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && load_req) begin
                repeat (2) @(negedge clk);
                load_ack = 1'b1;
                @(negedge clk);
                load_ack = 1'b0;
            end
        end
    end

    task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [SW-1:0] s);
        load_q.push_back({a, s});
        fwd_q.push_back({a, d, s});
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_data = d;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_fwd(input int n);
        while (fwds_seen < n) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic probe_claim(input logic [AW-1:0] a, input bit exp, input string req);
        @(negedge clk);
        in_addr = a;
        #1;
        check(claim == exp, req, claim, exp);
    endtask

    task automatic finish_unit(input logic [SW-1:0] s);
        @(negedge clk);
        done_valid = 1'b1; done_slot = s;
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(load_req == 1'b0, "R1 load_req after reset", load_req, 0);
        check(fwd_valid == 1'b0, "R1 fwd_valid after reset", fwd_valid, 0);
        probe_claim(12'h123, 1'b1, "R1 claim after reset");
        probe_claim(12'hFFF, 1'b1, "R2 claim for non-resident");

        // R2/R3/R4/R7: first miss, held valid to observe back-pressure
        load_q.push_back({12'h123, 2'd0});
        fwd_q.push_back({12'h123, 32'hA5A5_0001, 2'd0});
        @(negedge clk);
        in_valid = 1'b1; in_addr = 12'h123; in_data = 32'hA5A5_0001;
        #1;
        check(in_ready == 1'b1, "R2 in_ready for idle miss", in_ready, 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
            check(in_ready == 1'b0, "R7 back-pressure same FU during load", in_ready, 0);
        end
        in_valid = 1'b0;
        wait_fwd(1);

        // R5: address now resident
        probe_claim(12'h123, 1'b0, "R5 claim dropped for resident");
        in_valid = 1'b1;
        repeat (4) begin
            @(negedge clk);
            #1;
            check(in_ready == 1'b0, "R5 resident address not accepted", in_ready, 0);
        end
        in_valid = 1'b0;

        // Fill remaining slots (R9 lowest free)
        send(12'h200, 32'h0000_0B0B, 2'd1);
        wait_fwd(2);
        send(12'h301, 32'h0000_0C0C, 2'd2);
        wait_fwd(3);
        send(12'h042, 32'h0000_0D0D, 2'd3);
        wait_fwd(4);

        // R8: table full, new miss must wait
        send(12'h555, 32'h5555_5555, 2'd2);
        repeat (10) @(negedge clk);
        check(loads_seen == 4, "R8 no load while full", loads_seen, 4);
        finish_unit(2'd2);
        wait_fwd(5);
        check(loads_seen == 5, "R8 load after slot freed", loads_seen, 5);

        // R6: completion reclaims address
        finish_unit(2'd0);
        probe_claim(12'h123, 1'b1, "R6 address claimed again");
        // R10: completion on empty slot leaves others
        finish_unit(2'd0);
        probe_claim(12'h200, 1'b0, "R10 slot1 still resident");
        probe_claim(12'h555, 1'b0, "R10 slot2 still resident");
        probe_claim(12'h042, 1'b0, "R10 slot3 still resident");

        // R9: freed slot 0 is the lowest free one
        send(12'h777, 32'h7777_0007, 2'd0);
        wait_fwd(6);
        check(load_q.size() == 0, "R3 all loads seen", load_q.size(), 0);
        check(fwd_q.size() == 0, "R4 all forwards seen", fwd_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule